// File: doc/BRIEF.md
# System Option Register with Wake Stabilisation

This block is a small configuration unit for a microcontroller core. It keeps one 8-bit option register, written and read over a plain register port, and turns its fields into three behaviours:

- It conditions the active-low external interrupt pin, either as a low-level wired-OR request or as a falling-edge latch that is cleared by an acknowledge.
- It sequences the core's exit from STOP, optionally holding the resume signal low for an oscillator-settling interval.
- It drives a clock-monitor enable.

Several fields are protected. They accept only the first write made in a short window after reset release. After that they keep their value until the next reset.

Register layout:

| Bit | Field | Write access |
|-----|-------|--------------|
| 7 | clock-source select | free, any time |
| 6 | reserved, reads 0 | — |
| 5 | IRQ edge mode (1 = falling edge, 0 = low level) | protected |
| 4 | wake-delay enable | protected |
| 3 | clock-monitor enable | free, any time |
| 2 | not implemented, reads 0 | — |
| 1:0 | timer-rate select | protected |

Top module: `sysopt_ctrl`

## Requirements
- R1: While reset is applied and directly after it, the register reads 0x10: delay enable is set and every other field is zero. run_ok is 1, clkmon_en is 0 and irq_req is 0 while the pin is high.
- R2: Bits 6 and 2 of bus_rdata always read 0, whatever is written.
- R3: Bits 7 (clock-source select) and 3 (clock-monitor enable) take the written value on every bus_wr, at any time. clkmon_en and clk_src_sel follow them one cycle after the write edge.
- R4: Bits 5, 4 and 1:0 take the written value only on the first bus_wr whose edge falls within the first 64 clock edges after reset release (edges 0 to 63). Every other write leaves them unchanged.
- R5: With bit 5 = 0, irq_req is 1 on the cycle after an edge that sampled irq_n_pin low. It stays 1 while the pin stays low and returns to 0 one edge after the pin rises.
- R6: With bit 5 = 1, a high-to-low transition of irq_n_pin sets a pending request, and irq_req stays 1 until irq_ack is sampled. A pin held low does not set it again.
- R7: With bit 5 = 1, a falling edge sampled on the same edge as irq_ack leaves the request set.
- R8: With bit 4 = 1, a wake_evt in STOP keeps run_ok at 0 for 4064 clock edges after the wake edge. run_ok becomes 1 after the 4064th following edge.
- R9: With bit 4 = 0, run_ok returns to 1 on the edge that samples wake_evt in STOP.
- R10: A stop_req that arrives while the wake delay is counting is ignored. The count completes and run_ok rises and stays 1.
- R11: stop_req while running drops run_ok on the next edge. wake_evt while running has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| irq_n_pin | input | 1 | External interrupt pin, active low |
| irq_ack | input | 1 | One-cycle acknowledge of an edge request |
| stop_req | input | 1 | Core enters STOP |
| wake_evt | input | 1 | Wake event while stopped |
| run_ok | output | 1 | Core may execute |
| irq_req | output | 1 | Conditioned interrupt request |
| clkmon_en | output | 1 | Clock-monitor enable |
| clk_src_sel | output | 1 | Clock-source select field |
| tmr_rate | output | 2 | Timer-rate select field |

## Verification
The interrupt conditioner is driven with pin patterns that separate the two senses:
- a falling edge, and the pin then held low, which tells an edge latch from a level follower;
- an acknowledge with the pin still low, which shows edge mode does not re-trigger;
- an acknowledge on the same edge as a new fall, which checks the keep-set priority;
- a rising pin under level sense.

Register writes are placed at edge 0, edge 63 and edge 64 after reset. Second writes inside the window separate "first write only" from "any write in the window". The wake sequence is run with the delay enabled, with a stop request injected mid-count, and with the delay bypassed. Its output is sampled at exactly edge 4063 and edge 4064 after the wake.

// File: rtl/sysopt_pkg.sv
`timescale 1ns/1ps
package sysopt_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned B_CSRC = 7;
  localparam int unsigned B_IRQE = 5;
  localparam int unsigned B_WDLY = 4;
  localparam int unsigned B_CMON = 3;
  localparam logic [REG_W-1:0] FREE_MASK = 8'h88;
  localparam logic [REG_W-1:0] LOCK_MASK = 8'h33;
  localparam logic [REG_W-1:0] RST_VAL   = 8'h10;

  typedef enum logic [1:0] {WS_RUN, WS_STOP, WS_WAIT} wake_st_e;
endpackage

// File: rtl/sysopt_regfile.sv
`timescale 1ns/1ps
module sysopt_regfile
  import sysopt_pkg::*;
#(
  parameter int unsigned WIN_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] reg_q
);
  localparam int unsigned WIN_W = $clog2(WIN_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LIM = WIN_W'(WIN_CYC);

  logic [WIN_W-1:0] win_cnt;
  logic             win_used;
  logic             win_open;
  logic [REG_W-1:0] wmask;

  // Protected fields open only to the first write inside the window.
  assign win_open = (win_cnt < WIN_LIM) && !win_used;
  assign wmask    = FREE_MASK | (win_open ? LOCK_MASK : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= RST_VAL;
      win_cnt  <= '0;
      win_used <= 1'b0;
    end else begin
      if (win_cnt < WIN_LIM) win_cnt <= win_cnt + 1'b1;
      if (wr) begin
        reg_q <= (reg_q & ~wmask) | (wdata & wmask);
        if (win_open) win_used <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysopt_irq_cond.sv
`timescale 1ns/1ps
module sysopt_irq_cond (
  input  logic clk,
  input  logic rst,
  input  logic edge_mode,
  input  logic pin_n,
  input  logic ack,
  output logic req
);
  logic pin_d;
  logic lvl_q;
  logic pend_q;
  logic fall;

  assign fall = pin_d & ~pin_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_d  <= 1'b1;
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pin_d  <= pin_n;
      lvl_q  <= ~pin_n;
      // A new fall wins over an acknowledge on the same edge.
      pend_q <= edge_mode & (fall | (pend_q & ~ack));
    end
  end

  assign req = edge_mode ? pend_q : lvl_q;
endmodule

// File: rtl/sysopt_wake_seq.sv
`timescale 1ns/1ps
module sysopt_wake_seq
  import sysopt_pkg::*;
#(
  parameter int unsigned DLY_CYC = 4064
) (
  input  logic clk,
  input  logic rst,
  input  logic dly_en,
  input  logic stop_req,
  input  logic wake_evt,
  output logic run_ok
);
  localparam int unsigned CNT_W = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DLY_CYC - 1);

  wake_st_e         st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= WS_RUN;
      cnt    <= '0;
      run_ok <= 1'b1;
    end else begin
      unique case (st)
        WS_RUN: begin
          if (stop_req) begin
            st     <= WS_STOP;
            run_ok <= 1'b0;
          end
        end
        WS_STOP: begin
          if (wake_evt) begin
            if (dly_en) begin
              st  <= WS_WAIT;
              cnt <= CNT_LOAD;
            end else begin
              st     <= WS_RUN;
              run_ok <= 1'b1;
            end
          end
        end
        WS_WAIT: begin
          if (cnt == '0) begin
            st     <= WS_RUN;
            run_ok <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          st     <= WS_RUN;
          run_ok <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/sysopt_ctrl.sv
`timescale 1ns/1ps
module sysopt_ctrl
  import sysopt_pkg::*;
#(
  parameter int unsigned WIN_CYC = 64,
  parameter int unsigned DLY_CYC = 4064
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_n_pin,
  input  logic       irq_ack,
  input  logic       stop_req,
  input  logic       wake_evt,
  output logic       run_ok,
  output logic       irq_req,
  output logic       clkmon_en,
  output logic       clk_src_sel,
  output logic [1:0] tmr_rate
);
  logic [REG_W-1:0] opt_q;

  sysopt_regfile #(.WIN_CYC(WIN_CYC)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .reg_q (opt_q)
  );

  sysopt_irq_cond u_irq (
    .clk       (clk),
    .rst       (rst),
    .edge_mode (opt_q[B_IRQE]),
    .pin_n     (irq_n_pin),
    .ack       (irq_ack),
    .req       (irq_req)
  );

  sysopt_wake_seq #(.DLY_CYC(DLY_CYC)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .dly_en   (opt_q[B_WDLY]),
    .stop_req (stop_req),
    .wake_evt (wake_evt),
    .run_ok   (run_ok)
  );

  assign bus_rdata   = opt_q;
  assign clkmon_en   = opt_q[B_CMON];
  assign clk_src_sel = opt_q[B_CSRC];
  assign tmr_rate    = opt_q[1:0];
endmodule

// File: rtl/sysopt_ctrl_chk.sv
`timescale 1ns/1ps
module sysopt_ctrl_chk #(
  parameter int unsigned WIN_CYC = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       irq_n_pin,
  input logic       irq_ack,
  input logic       stop_req,
  input logic       wake_evt,
  input logic [7:0] bus_rdata,
  input logic       run_ok,
  input logic       irq_req
);
  localparam int unsigned CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(WIN_CYC);
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (seen < LIM) seen <= seen + 1'b1;
  end

  a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[6] == 1'b0) && (bus_rdata[2] == 1'b0));

  a_r4_locked_after_window: assert property (@(posedge clk) disable iff (rst)
    (seen >= LIM) |=> $stable({bus_rdata[5:4], bus_rdata[1:0]}));

  a_r5_level_follow: assert property (@(posedge clk) disable iff (rst)
    (!bus_rdata[5] && !irq_n_pin) |=> (irq_req || bus_rdata[5]));

  a_r6_pending_holds: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[5] && irq_req && !irq_ack) |=> (irq_req || !bus_rdata[5]));

  a_r7_edge_beats_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[5] && $past(irq_n_pin) && !irq_n_pin && irq_ack) |=> (irq_req || !bus_rdata[5]));

  a_r8_delay_holds: assert property (@(posedge clk) disable iff (rst)
    (!run_ok && wake_evt && bus_rdata[4]) |=> !run_ok);

  a_r11_stop_drops: assert property (@(posedge clk) disable iff (rst)
    (run_ok && stop_req) |=> !run_ok);
endmodule

bind sysopt_ctrl sysopt_ctrl_chk #(.WIN_CYC(WIN_CYC)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_n_pin (irq_n_pin),
  .irq_ack   (irq_ack),
  .stop_req  (stop_req),
  .wake_evt  (wake_evt),
  .bus_rdata (bus_rdata),
  .run_ok    (run_ok),
  .irq_req   (irq_req)
);

// File: tb/test_sysopt_ctrl.sv
`timescale 1ns/1ps
module test_sysopt_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_n_pin = 1'b1;
  logic       irq_ack = 1'b0;
  logic       stop_req = 1'b0;
  logic       wake_evt = 1'b0;
  logic       run_ok, irq_req, clkmon_en, clk_src_sel;
  logic [1:0] tmr_rate;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sysopt_ctrl i_sysopt_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n_pin(irq_n_pin), .irq_ack(irq_ack),
    .stop_req(stop_req), .wake_evt(wake_evt), .run_ok(run_ok),
    .irq_req(irq_req), .clkmon_en(clkmon_en), .clk_src_sel(clk_src_sel),
    .tmr_rate(tmr_rate)
  );

  // Edge-mode vectors {pin, ack, expected irq_req after the edge}
  localparam logic [2:0] EVEC [0:8] = '{
    3'b100,  // idle high
    3'b001,  // fall sets pending (R6)
    3'b001,  // pin held low, stays set (R6)
    3'b010,  // ack with pin low clears, no retrigger (R6)
    3'b100,  // rise, nothing
    3'b011,  // fall together with ack stays set (R7)
    3'b001,  // still set (R7)
    3'b110,  // ack clears (R6)
    3'b100   // idle
  };

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    rst = 1'b1;
    bus_wr = 1'b0; irq_n_pin = 1'b1; irq_ack = 1'b0;
    stop_req = 1'b0; wake_evt = 1'b0;
    repeat (3) step;
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    bus_wr = 1'b1; bus_wdata = d;
    step;
    bus_wr = 1'b0;
  endtask

  initial begin
    do_reset;
    chk("R1 reset value", bus_rdata, 8'h10);
    chk("R1 run_ok", run_ok, 1);
    chk("R1 clkmon_en", clkmon_en, 0);
    chk("R1 irq_req", irq_req, 0);

    wr(8'hFF);  // edge 0: first write in window
    chk("R4 first write", bus_rdata, 8'hBB);
    chk("R2 unimpl bits zero", {bus_rdata[6], bus_rdata[2]}, 0);
    chk("R3 clkmon_en set", clkmon_en, 1);
    chk("R4 tmr_rate", tmr_rate, 2'b11);
    wr(8'h00);  // second write: only free fields
    chk("R4 second write locked", bus_rdata, 8'h33);
    chk("R3 clkmon_en cleared", clkmon_en, 0);
    chk("R3 clk_src_sel cleared", clk_src_sel, 0);
    wr(8'h88);
    chk("R3 free bits rewritten", bus_rdata, 8'hBB);

    for (int i = 0; i < 9; i++) begin
      irq_n_pin = EVEC[i][2];
      irq_ack   = EVEC[i][1];
      step;
      irq_ack = 1'b0;
      chk($sformatf("R6 R7 edge vector %0d", i), irq_req, EVEC[i][0]);
    end

    // Wake with delay enabled (bit 4 = 1)
    stop_req = 1'b1; step; stop_req = 1'b0;
    chk("R11 stop drops run_ok", run_ok, 0);
    wake_evt = 1'b1; step; wake_evt = 1'b0;
    chk("R8 held after wake", run_ok, 0);
    repeat (2000) step;
    stop_req = 1'b1; step; stop_req = 1'b0;  // R10: ignored mid-count
    repeat (2062) step;
    chk("R8 low at edge 4063", run_ok, 0);
    step;
    chk("R8 high at edge 4064", run_ok, 1);
    step;
    chk("R10 stop during count ignored", run_ok, 1);

    // Late write outside window, level mode
    do_reset;
    repeat (64) step;
    wr(8'hFF);  // edge 64
    chk("R4 write at edge 64 rejected", bus_rdata, 8'h98);
    irq_n_pin = 1'b0; step;
    chk("R5 level low asserts", irq_req, 1);
    step;
    chk("R5 level held", irq_req, 1);
    irq_n_pin = 1'b1; step;
    chk("R5 level release", irq_req, 0);
    wake_evt = 1'b1; step; wake_evt = 1'b0;
    chk("R11 wake while running", run_ok, 1);

    // Write at last window edge, delay bypassed
    do_reset;
    repeat (63) step;
    wr(8'h00);  // edge 63
    chk("R4 write at edge 63 accepted", bus_rdata, 8'h00);
    wr(8'h10);
    chk("R4 later write in window ignored", bus_rdata, 8'h00);
    stop_req = 1'b1; step; stop_req = 1'b0;
    chk("R11 stop drops run_ok bypass", run_ok, 0);
    step;
    chk("R9 still stopped without wake", run_ok, 0);
    wake_evt = 1'b1; step; wake_evt = 1'b0;
    chk("R9 bypass resumes at once", run_ok, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule